// File: doc/BRIEF.md
# Indexed Generated-Clock Controller

This block holds a generated-clock setting for every peripheral slot behind one shared, indexed control register. A bus master writes a word carrying a slot identifier. With the command bit clear, that write only points the register at the slot, and a later read returns the slot's stored enable, source and divider. With the command bit set, the write also stores new enable, source and divider values for that slot.

Each slot drives its own output clock. The output is a divided, gated copy of one of several input sources. The sources arrive as single-cycle tick strobes in the bus clock domain, one strobe per half-period of the source clock. Each slot runs a small state machine with three states. `SLOT_OFF` holds the output low. `SLOT_RUN` divides the active source. `SLOT_DRAIN` finishes the current output period before the slot parks. The transitions are: *start* (OFF to RUN, when the stored enable is set; the stored source and divider are loaded as the active copy), *hold* (RUN to RUN, stored settings equal the active ones), *retire* (RUN to DRAIN, stored settings differ or enable is clear), *park* (RUN or DRAIN to OFF, at the tick that ends a period, or at once if the active source is reserved) and *drain* (DRAIN to DRAIN otherwise). Because new settings are only loaded in OFF, a change never cuts a pulse short.

Top module: `gclk_ctrl`

## Requirements
- R1: After reset every slot is disabled with source 0 and divider 0. The selected identifier is 0. The read data is all zero and every output clock is low.
- R2: A write whose command bit (bit 12) is clear, and whose identifier is valid, latches the identifier as the selected slot. It changes no slot's stored enable, source or divider, and no running output.
- R3: A read returns the selected identifier in bits [5:0], its source in bits [10:8], its divider in bits [27:20] and its enable in bit 29. Every other bit, including bit 12, reads as zero.
- R4: A write with bit 12 set and a valid identifier selects that slot. It stores bit 29 as the enable, bits [10:8] as the source and bits [27:20] as the divider.
- R5: Writes carrying identifier 0 or 1 have no effect on the selection or on any slot, and outputs 0 and 1 stay low. Valid identifiers are 2 to 63.
- R6: With divider value D, a running output repeats every 2(D+1) source ticks. For even D+1 it is high for D+1 ticks. For odd D+1 greater than 1 it is high for D ticks, one source cycle less than the low phase. For D+1 = 1 it is high for one tick and low for one tick.
- R7: Source values 0 to 5 select bit 0 to 5 of `src_tick`. Values 6 and 7 are reserved: they can be stored and read back, but a slot using them keeps its output low.
- R8: A command write with the enable bit clear stops the output after the current period and keeps the stored source and divider. A later enable resumes with those settings.
- R9: A new source or divider on a running slot takes effect only after the current period has ended and the slot has spent one cycle in OFF. No high phase is ever shortened.
- R10: From OFF, a commit captured on clock edge E makes the output high from edge E+1 when the source is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and control clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 32 | Write data of the control register |
| rd_data | output | 32 | Read view of the selected slot |
| src_tick | input | 6 | One strobe per half-period of each input source |
| gclk_out | output | 64 | Generated clock of each slot |

## Verification
The hardest case is a commit to a running slot that is seen by the slot on the same edge as the tick that ends its output period. In that cycle the retire and park transitions fall together. The bench uses its behavioural model's tick count to place a commit one edge before the wrapping tick. It then checks that the output is low for exactly one parked cycle and high on the next. A cycle-by-cycle model also compares every output and the read data on every clock. This covers any other overlap, such as a select write arriving while slots change phase.

// File: rtl/gclk_pkg.sv
package gclk_pkg;
    localparam int REG_W   = 32;
    localparam int ID_W    = 6;
    localparam int SRC_W   = 3;
    localparam int DIV_W   = 8;
    localparam int CNT_W   = DIV_W + 1;
    localparam int ID_LSB  = 0;
    localparam int SRC_LSB = 8;
    localparam int CMD_BIT = 12;
    localparam int DIV_LSB = 20;
    localparam int EN_BIT  = 29;

    typedef struct packed {
        logic             en;
        logic [SRC_W-1:0] src;
        logic [DIV_W-1:0] div;
    } slot_cfg_t;

    typedef enum logic [1:0] {
        SLOT_OFF   = 2'd0,
        SLOT_RUN   = 2'd1,
        SLOT_DRAIN = 2'd2
    } slot_state_e;

    // ticks of high phase for a divider field value
    function automatic logic [CNT_W-1:0] high_ticks(input logic [DIV_W-1:0] d);
        logic [CNT_W-1:0] n;
        n = {1'b0, d} + CNT_W'(1);
        if (n == CNT_W'(1))
            return CNT_W'(1);
        else if (!n[0])
            return n;
        else
            return n - CNT_W'(1);
    endfunction

    // last counter value of a period of 2*(d+1) ticks
    function automatic logic [CNT_W-1:0] last_tick(input logic [DIV_W-1:0] d);
        return {d, 1'b1};
    endfunction
endpackage

// File: rtl/gclk_regif.sv
module gclk_regif
    import gclk_pkg::*;
#(
    parameter int N_SLOTS = 64,
    parameter int ID_MIN  = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [REG_W-1:0]          wr_data,
    output logic [REG_W-1:0]          rd_data,
    output slot_cfg_t [N_SLOTS-1:0]   cfg_o
);
    logic [ID_W-1:0]          w_id;
    logic                     w_ok;
    logic                     w_cmd;
    slot_cfg_t                w_cfg;
    logic [ID_W-1:0]          sel_q;
    slot_cfg_t [N_SLOTS-1:0]  cfg_q;
    logic                     unused_wr;

    assign w_id      = wr_data[ID_LSB +: ID_W];
    assign w_cmd     = wr_data[CMD_BIT];
    assign w_ok      = wr_en && (w_id >= ID_W'(ID_MIN));
    assign w_cfg.en  = wr_data[EN_BIT];
    assign w_cfg.src = wr_data[SRC_LSB +: SRC_W];
    assign w_cfg.div = wr_data[DIV_LSB +: DIV_W];
    assign unused_wr = ^{wr_data[7:6], wr_data[11], wr_data[19:13],
                         wr_data[28], wr_data[31:30]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            cfg_q <= '0;
        end else if (w_ok) begin
            sel_q <= w_id;
            if (w_cmd)
                cfg_q[w_id] <= w_cfg;
        end
    end

    always_comb begin
        rd_data                       = '0;
        rd_data[ID_LSB  +: ID_W]      = sel_q;
        rd_data[SRC_LSB +: SRC_W]     = cfg_q[sel_q].src;
        rd_data[DIV_LSB +: DIV_W]     = cfg_q[sel_q].div;
        rd_data[EN_BIT]               = cfg_q[sel_q].en;
    end

    assign cfg_o = cfg_q;

    // R2
    select_only_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[CMD_BIT]) |=> $stable(cfg_q));

    // R5
    low_id_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_data[ID_LSB +: ID_W] < ID_W'(ID_MIN)))
            |=> ($stable(sel_q) && $stable(cfg_q)));

    // R4
    commit_store_chk: assert property (@(posedge clk) disable iff (rst)
        (w_ok && w_cmd) |=> ((sel_q == $past(w_id)) && (cfg_q[sel_q] == $past(w_cfg))));
endmodule

// File: rtl/gclk_slot.sv
module gclk_slot
    import gclk_pkg::*;
#(
    parameter int N_SRC = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_cfg_t         cfg_i,
    input  logic [N_SRC-1:0]  src_tick,
    output logic              gclk_o
);
    slot_state_e       st_q, st_d;
    logic [SRC_W-1:0]  act_src_q, act_src_d;
    logic [DIV_W-1:0]  act_div_q, act_div_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              out_q, out_d;
    logic              src_ok, src_ok_d, tick, changed, stopping, at_end;

    // source mux and period-end detect on the active copy
    always_comb begin
        src_ok = ({1'b0, act_src_q} < (SRC_W+1)'(N_SRC));
        tick   = 1'b0;
        for (int k = 0; k < N_SRC; k++)
            if (act_src_q == SRC_W'(k))
                tick = src_tick[k];
        changed  = !cfg_i.en || (cfg_i.src != act_src_q) || (cfg_i.div != act_div_q);
        stopping = (st_q == SLOT_DRAIN) || changed;
        at_end   = tick && (cnt_q == last_tick(act_div_q));
    end

    // next state
    always_comb begin
        st_d      = st_q;
        act_src_d = act_src_q;
        act_div_d = act_div_q;
        cnt_d     = cnt_q;
        unique case (st_q)
            SLOT_OFF: begin
                if (cfg_i.en) begin
                    st_d      = SLOT_RUN;
                    act_src_d = cfg_i.src;
                    act_div_d = cfg_i.div;
                    cnt_d     = '0;
                end
            end
            SLOT_RUN, SLOT_DRAIN: begin
                if (stopping && (!src_ok || at_end)) begin
                    st_d  = SLOT_OFF;
                    cnt_d = '0;
                end else begin
                    st_d = stopping ? SLOT_DRAIN : SLOT_RUN;
                    if (tick)
                        cnt_d = at_end ? '0 : cnt_q + CNT_W'(1);
                end
            end
            default: st_d = SLOT_OFF;
        endcase
        src_ok_d = ({1'b0, act_src_d} < (SRC_W+1)'(N_SRC));
        out_d    = (st_d != SLOT_OFF) && src_ok_d && (cnt_d < high_ticks(act_div_d));
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= SLOT_OFF;
            act_src_q <= '0;
            act_div_q <= '0;
            cnt_q     <= '0;
        end else begin
            st_q      <= st_d;
            act_src_q <= act_src_d;
            act_div_q <= act_div_d;
            cnt_q     <= cnt_d;
        end
    end

    // registered output, free of glitches
    always_ff @(posedge clk) begin
        if (rst)
            out_q <= 1'b0;
        else
            out_q <= out_d;
    end

    assign gclk_o = out_q;

    // R1
    off_low_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == SLOT_OFF) |-> !out_q);

    // R9
    hold_active_chk: assert property (@(posedge clk) disable iff (rst)
        ((st_q != SLOT_OFF) && ($past(st_q) != SLOT_OFF))
            |-> ($stable(act_src_q) && $stable(act_div_q)));

    // R9
    park_from_low_chk: assert property (@(posedge clk) disable iff (rst)
        ((st_q == SLOT_OFF) && ($past(st_q) != SLOT_OFF)) |-> !$past(out_q));

    // R7
    reserved_low_chk: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, act_src_q} >= (SRC_W+1)'(N_SRC)) |-> !out_q);

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last_tick(act_div_q));
endmodule

// File: rtl/gclk_ctrl.sv
module gclk_ctrl
    import gclk_pkg::*;
#(
    parameter int N_SLOTS = 64,
    parameter int ID_MIN  = 2,
    parameter int N_SRC   = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [31:0]         wr_data,
    output logic [31:0]         rd_data,
    input  logic [N_SRC-1:0]    src_tick,
    output logic [N_SLOTS-1:0]  gclk_out
);
    slot_cfg_t [N_SLOTS-1:0] cfg;

    gclk_regif #(
        .N_SLOTS (N_SLOTS),
        .ID_MIN  (ID_MIN)
    ) u_regif (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .cfg_o   (cfg)
    );

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        gclk_slot #(
            .N_SRC (N_SRC)
        ) u_slot (
            .clk      (clk),
            .rst      (rst),
            .cfg_i    (cfg[g]),
            .src_tick (src_tick),
            .gclk_o   (gclk_out[g])
        );
    end
endmodule

// File: tb/test_gclk_ctrl.sv
module test_gclk_ctrl;
    localparam int NS    = 64;
    localparam int IDMIN = 2;
    localparam int NSRC  = 6;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic [31:0]     wr_data = '0;
    logic [31:0]     rd_data;
    logic [NSRC-1:0] src_tick = '0;
    logic [NS-1:0]   gclk_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit chk_on  = 0;
    bit tick_all = 1;
    int cyc = 0;

    // behavioural reference
    int m_en [NS];
    int m_src [NS];
    int m_div [NS];
    int m_st [NS];
    int m_asrc [NS];
    int m_adiv [NS];
    int m_cnt [NS];
    bit m_out [NS];
    int m_sel;

    gclk_ctrl i_gclk_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .src_tick (src_tick),
        .gclk_out (gclk_out)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int id, input bit cmd, input bit en,
                                       input int src, input int div);
        logic [31:0] v;
        v        = '0;
        v[5:0]   = 6'(id);
        v[12]    = cmd;
        v[10:8]  = 3'(src);
        v[27:20] = 8'(div);
        v[29]    = en;
        return v;
    endfunction

    // tick strobes, changed away from the active edge
    always @(negedge clk) begin
        cyc++;
        for (int k = 0; k < NSRC; k++)
            src_tick[k] <= tick_all ? 1'b1 : ((cyc % (k + 1)) == 0);
    end

    // reference model, advanced on each edge
    always @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NS; s++) begin
                m_en[s] = 0; m_src[s] = 0; m_div[s] = 0; m_st[s] = 0;
                m_asrc[s] = 0; m_adiv[s] = 0; m_cnt[s] = 0; m_out[s] = 0;
            end
            m_sel = 0;
        end else begin
            for (int s = 0; s < NS; s++) begin
                bit ok, t, chg, stop;
                int last, n, hi;
                ok   = m_asrc[s] < NSRC;
                t    = ok ? src_tick[m_asrc[s]] : 1'b0;
                last = 2 * (m_adiv[s] + 1) - 1;
                if (m_st[s] == 0) begin
                    if (m_en[s] != 0) begin
                        m_st[s] = 1; m_asrc[s] = m_src[s]; m_adiv[s] = m_div[s]; m_cnt[s] = 0;
                    end
                end else begin
                    chg  = (m_en[s] == 0) || (m_src[s] != m_asrc[s]) || (m_div[s] != m_adiv[s]);
                    stop = (m_st[s] == 2) || chg;
                    if (stop && (!ok || (t && m_cnt[s] == last))) begin
                        m_st[s] = 0; m_cnt[s] = 0;
                    end else begin
                        m_st[s] = stop ? 2 : 1;
                        if (t) m_cnt[s] = (m_cnt[s] == last) ? 0 : m_cnt[s] + 1;
                    end
                end
                n  = m_adiv[s] + 1;
                hi = (n == 1) ? 1 : ((n % 2 == 0) ? n : n - 1);
                m_out[s] = (m_st[s] != 0) && (m_asrc[s] < NSRC) && (m_cnt[s] < hi);
            end
            if (wr_en && wr_data[5:0] >= IDMIN) begin
                m_sel = int'(wr_data[5:0]);
                if (wr_data[12]) begin
                    m_en[m_sel]  = int'(wr_data[29]);
                    m_src[m_sel] = int'(wr_data[10:8]);
                    m_div[m_sel] = int'(wr_data[27:20]);
                end
            end
        end
    end

    // compare on every clock
    always @(negedge clk) begin
        if (chk_on) begin
            logic [NS-1:0] ev;
            logic [31:0]   er;
            for (int s = 0; s < NS; s++) ev[s] = m_out[s];
            er = mk(m_sel, 1'b0, m_en[m_sel] != 0, m_src[m_sel], m_div[m_sel]);
            check(gclk_out == ev, "R6", "outputs vs model", gclk_out, ev);
            check(rd_data == er, "R3", "read data vs model", rd_data, er);
        end
    end

    task automatic bus_wr(input logic [31:0] v);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic count_high(input int s, input int ncyc, output int c);
        c = 0;
        repeat (ncyc) begin
            @(negedge clk);
            if (gclk_out[s]) c++;
        end
    endtask

    task automatic high_runs(input int s, input int ncyc, output int bad);
        int run;
        bit armed;
        run = 0; armed = 0; bad = 0;
        repeat (ncyc) begin
            @(negedge clk);
            if (gclk_out[s]) run++;
            else begin
                if (armed && run != 0 && run != 2 && run != 4) bad++;
                armed = 1;
                run = 0;
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        int c, bad;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(rd_data == 32'h0, "R1", "read after reset", rd_data, 0);
        check(gclk_out == '0, "R1", "outputs after reset", gclk_out, 0);
        chk_on = 1;

        // R2 select only, with junk fields
        bus_wr(mk(5, 0, 1, 3, 7));
        check(rd_data == 32'h5, "R2", "select readback", rd_data, 32'h5);

        // R4 commit and R3 layout
        bus_wr(mk(5, 1, 1, 0, 3));
        check(rd_data == mk(5, 0, 1, 0, 3), "R4", "commit readback", rd_data, mk(5, 0, 1, 0, 3));
        check(rd_data[12] == 1'b0, "R3", "command bit reads zero", rd_data[12], 0);
        repeat (4) @(negedge clk);
        count_high(5, 32, c);
        check(c == 16, "R6", "even divisor 4 duty", c, 16);

        // R6 odd and extreme divisors
        bus_wr(mk(6, 1, 1, 0, 2));
        repeat (4) @(negedge clk);
        count_high(6, 36, c);
        check(c == 12, "R6", "odd divisor 3 high ticks", c, 12);
        bus_wr(mk(7, 1, 1, 0, 0));
        repeat (3) @(negedge clk);
        count_high(7, 20, c);
        check(c == 10, "R6", "divisor 1", c, 10);
        bus_wr(mk(8, 1, 1, 0, 255));
        repeat (3) @(negedge clk);
        count_high(8, 512, c);
        check(c == 256, "R6", "divisor 256", c, 256);

        // R2 select does not disturb slot 5
        bus_wr(mk(5, 0, 0, 5, 9));
        check(rd_data == mk(5, 0, 1, 0, 3), "R2", "settings kept on select", rd_data, mk(5, 0, 1, 0, 3));
        count_high(5, 32, c);
        check(c == 16, "R2", "slot 5 still running", c, 16);

        // R5 identifiers 0 and 1 ignored
        bus_wr(mk(1, 1, 1, 0, 0));
        bus_wr(mk(0, 0, 0, 0, 0));
        check(rd_data == mk(5, 0, 1, 0, 3), "R5", "selection kept", rd_data, mk(5, 0, 1, 0, 3));
        count_high(1, 20, c);
        check(c == 0, "R5", "output 1 low", c, 0);

        // R7 source mux with patterned ticks, reserved sources
        tick_all = 0;
        bus_wr(mk(9, 1, 1, 2, 0));
        repeat (12) @(negedge clk);
        count_high(9, 60, c);
        check(c == 30, "R7", "source 2 divided by 1", c, 30);
        bus_wr(mk(10, 1, 1, 6, 1));
        check(rd_data[10:8] == 3'd6, "R7", "reserved source readback", rd_data[10:8], 6);
        bus_wr(mk(11, 1, 1, 7, 0));
        count_high(10, 40, c);
        check(c == 0, "R7", "source 6 held low", c, 0);
        count_high(11, 20, c);
        check(c == 0, "R7", "source 7 held low", c, 0);

        // R8 disable keeps settings, resume
        bus_wr(mk(5, 1, 0, 0, 3));
        repeat (12) @(negedge clk);
        count_high(5, 20, c);
        check(c == 0, "R8", "disabled output", c, 0);
        bus_wr(mk(5, 0, 0, 0, 0));
        check(rd_data == mk(5, 0, 0, 0, 3), "R8", "settings retained", rd_data, mk(5, 0, 0, 0, 3));
        bus_wr(mk(5, 1, 1, 0, 3));
        repeat (4) @(negedge clk);
        count_high(5, 32, c);
        check(c == 16, "R8", "resume same divisor", c, 16);

        // R9 divider change while running
        tick_all = 1;
        repeat (3) @(negedge clk);
        bus_wr(mk(5, 1, 1, 0, 1));
        high_runs(5, 80, bad);
        check(bad == 0, "R9", "truncated high phases", bad, 0);
        count_high(5, 16, c);
        check(c == 8, "R9", "new divisor applied", c, 8);

        // R10 enable latency
        bus_wr(mk(12, 1, 1, 0, 4));
        check(gclk_out[12] == 1'b0, "R10", "low at commit edge", gclk_out[12], 0);
        @(negedge clk);
        check(gclk_out[12] == 1'b1, "R10", "high one edge later", gclk_out[12], 1);

        // R9 commit seen on the period-ending tick
        while (!(m_st[5] == 1 && m_cnt[5] == 2)) @(negedge clk);
        bus_wr(mk(5, 1, 1, 0, 2));
        @(negedge clk);
        check(gclk_out[5] == 1'b0, "R9", "parked at coincident end", gclk_out[5], 0);
        @(negedge clk);
        check(gclk_out[5] == 1'b1, "R9", "restart after park", gclk_out[5], 1);
        repeat (20) @(negedge clk);

        chk_on = 0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule